// File: doc/BRIEF.md
# Linked Descriptor Chain Walker

This block follows a chain of in-memory descriptors and turns each of them into transfer commands for a data mover. Writing a start address and pulsing `start` launches a run. For every descriptor the walker reads six words through a word-read port. The words are, in order: header, first length, first pointer, second length, second pointer, and next-descriptor address. The walker then checks the header's parity. The first length/pointer pair is the input half and the second is the output half. Each half that is in use becomes either one direct segment command or, when header bit 24 is set, a walk of a secondary chain of three-word link entries (length, data address, next-link address). Each link entry becomes one segment command.

A run ends when a null next-descriptor address is reached, which raises a one-cycle `done` pulse. A run also ends at the first detected fault, which raises a one-cycle `err` pulse with a code on `err_code`. The cipher datapath, bus fabric and data movement are handled elsewhere.

Both the memory port and the segment port use valid/ready. A request or segment stays stable while valid is high and ready is low. Once the payload is offered, valid does not fall until the handshake completes. Holding `seg_ready` low stalls the whole walk, and no further memory reads are issued while a segment waits. Holding `mem_req_ready` low or delaying `mem_rsp_valid` stalls the walk the same way.

Top module: `desc_chain_walker`

## Requirements
- R1: Exactly one memory read is outstanding at any time. A descriptor's six words are read from consecutive word addresses starting at the descriptor address, and a link's three words are read from consecutive word addresses starting at the link address. A request is held stable until accepted.
- R2: A header word (word 0) whose 32 bits hold an even number of ones is rejected with error code 1 (bit 31 is the parity bit). No segment is issued for that descriptor.
- R3: With header bit 24 clear, each half in use produces one segment carrying that half's length and pointer. The input half (words 1 and 2, `seg_dir`=0) comes before the output half (words 3 and 4, `seg_dir`=1).
- R4: A half whose length and pointer are both zero is skipped and produces no segment.
- R5: With header bit 24 set, each half's pointer heads a link chain. Every link produces one segment (its length and data address, with the half's direction), and a link whose next address is zero ends the chain.
- R6: If the sum of a chain's link lengths differs from the half's length, the run stops with error code 4. This happens after that chain's segments have been issued.
- R7: A chain may hold at most MAX_LINKS (default 20) links. If the last permitted link has a non-zero next address, the run stops with error code 5 once that link's segment has been issued.
- R8: A link chain head that is zero or not word aligned, or a non-zero next-link address that is not word aligned, stops the run with error code 13.
- R9: A start address that is zero or not word aligned, or a non-zero next-descriptor address that is not word aligned, stops the run with error code 12.
- R10: A non-zero next-descriptor address continues the walk at that descriptor. A zero next-descriptor address ends the run with a `done` pulse.
- R11: While `seg_valid` is high and `seg_ready` is low, the segment fields stay stable.
- R12: A `start` pulse while `busy` is high is ignored.
- R13: Each run ends with exactly one pulse, either `done` or `err`. `busy` is low in that cycle. `err_code` holds the code until the next start and reads 0 after a clean run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, taken only while idle |
| start_addr | input | WORD_W | Byte address of the first descriptor |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse: run ended cleanly |
| err | output | 1 | One-cycle pulse: run ended on a fault |
| err_code | output | 4 | Fault code of the last run (0 when clean) |
| mem_req_valid | output | 1 | Word read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | WORD_W | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Walker is waiting for read data |
| mem_rsp_data | input | WORD_W | Read data |
| seg_valid | output | 1 | Segment command valid |
| seg_ready | input | 1 | Data mover accepts the segment |
| seg_len | output | WORD_W | Segment length |
| seg_addr | output | WORD_W | Segment data address |
| seg_dir | output | 1 | 0 input half, 1 output half |

## Verification
If the internal word index or chain pointer goes wrong, the walker fetches the wrong word. That shows up at the segment port within one read latency as a segment whose length or address differs from the one the test placed in memory. A wrong half or skip decision shows as a missing, extra or misdirected segment in the ordered stream. A wrong running total or link count shows at the end of a chain, either as a spurious error pulse or as a clean end where code 4 or 5 was due. A stuck state shows as a missing outcome pulse, which the per-run timeout catches.

// File: rtl/dcw_pkg.sv
package dcw_pkg;
  localparam int DESC_WORDS = 6;
  localparam int LINK_WORDS = 3;
  localparam int LINKED_BIT = 24;

  typedef enum logic [3:0] {
    FAULT_NONE     = 4'd0,
    FAULT_HEADER   = 4'd1,
    FAULT_LINK_LEN = 4'd4,
    FAULT_LINK_CNT = 4'd5,
    FAULT_DESC_ADR = 4'd12,
    FAULT_LINK_ADR = 4'd13
  } fault_e;

  typedef enum logic [3:0] {
    W_IDLE, W_DESC_RD, W_DESC_CHK, W_HALF, W_SEG,
    W_LINK_RD, W_LINK_SEG, W_CHAIN_END, W_NEXT
  } walk_state_e;

  typedef enum logic [1:0] { RD_IDLE, RD_REQ, RD_WAIT } rd_state_e;
endpackage

// File: rtl/dcw_word_reader.sv
module dcw_word_reader import dcw_pkg::*; #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [WORD_W-1:0] addr,
  output logic              idle,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [WORD_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [WORD_W-1:0] mem_rsp_data
);
  rd_state_e st;
  logic [WORD_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= RD_IDLE;
      addr_q <= '0;
    end else begin
      case (st)
        RD_IDLE: if (go) begin addr_q <= addr; st <= RD_REQ; end
        RD_REQ:  if (mem_req_ready) st <= RD_WAIT;
        RD_WAIT: if (mem_rsp_valid) st <= RD_IDLE;
        default: st <= RD_IDLE;
      endcase
    end
  end

  assign idle          = (st == RD_IDLE);
  assign mem_req_valid = (st == RD_REQ);
  assign mem_req_addr  = addr_q;
  assign mem_rsp_ready = (st == RD_WAIT);
  assign word_valid    = (st == RD_WAIT) && mem_rsp_valid;
  assign word_data     = mem_rsp_data;

  assert_req_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  assert_single_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && mem_rsp_ready));
endmodule

// File: rtl/dcw_hdr_check.sv
module dcw_hdr_check import dcw_pkg::*; #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] hdr,
  output logic              parity_ok,
  output logic              linked
);
  assign parity_ok = ^hdr;
  assign linked    = hdr[LINKED_BIT];
endmodule

// File: rtl/dcw_link_tally.sv
module dcw_link_tally #(
  parameter int WORD_W    = 32,
  parameter int MAX_LINKS = 20,
  parameter int CNT_W     = $clog2(MAX_LINKS + 1),
  parameter int SUM_W     = WORD_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              add,
  input  logic [WORD_W-1:0] len,
  output logic [SUM_W-1:0]  sum,
  output logic [CNT_W-1:0]  count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum   <= '0;
      count <= '0;
    end else if (clr) begin
      sum   <= '0;
      count <= '0;
    end else if (add) begin
      sum   <= sum + SUM_W'(len);
      count <= count + 1'b1;
    end
  end

  assert_link_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(MAX_LINKS));
endmodule

// File: rtl/desc_chain_walker.sv
module desc_chain_walker import dcw_pkg::*; #(
  parameter int WORD_W    = 32,
  parameter int MAX_LINKS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] start_addr,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [3:0]        err_code,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [WORD_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              seg_valid,
  input  logic              seg_ready,
  output logic [WORD_W-1:0] seg_len,
  output logic [WORD_W-1:0] seg_addr,
  output logic              seg_dir
);
  localparam int IDX_W = $clog2(DESC_WORDS);
  localparam int CNT_W = $clog2(MAX_LINKS + 1);
  localparam int SUM_W = WORD_W + CNT_W;

  walk_state_e st;
  logic [WORD_W-1:0] dw [DESC_WORDS];
  logic [WORD_W-1:0] desc_ptr, link_ptr, lk_len, lk_next;
  logic [IDX_W-1:0]  idx;
  logic              half;
  logic              done_q, err_q, seg_valid_q;
  logic [3:0]        code_q;
  logic [WORD_W-1:0] seg_len_q, seg_addr_q;

  logic              rd_go, rd_idle, rd_word_valid;
  logic [WORD_W-1:0] rd_addr, rd_data;
  logic              parity_ok, linked;
  logic              t_clr, t_add;
  logic [SUM_W-1:0]  t_sum;
  logic [CNT_W-1:0]  t_cnt;
  logic [WORD_W-1:0] cur_len, cur_ptr;

  assign cur_len = half ? dw[3] : dw[1];
  assign cur_ptr = half ? dw[4] : dw[2];

  always_comb begin
    rd_go   = rd_idle && (st == W_DESC_RD || st == W_LINK_RD);
    rd_addr = ((st == W_LINK_RD) ? link_ptr : desc_ptr) + WORD_W'({idx, 2'b00});
    t_clr   = (st == W_HALF);
    t_add   = (st == W_LINK_RD) && rd_word_valid && (idx == IDX_W'(LINK_WORDS - 1));
  end

  dcw_word_reader #(.WORD_W(WORD_W)) u_reader (
    .clk, .rst_n, .go(rd_go), .addr(rd_addr), .idle(rd_idle),
    .word_valid(rd_word_valid), .word_data(rd_data),
    .mem_req_valid, .mem_req_ready, .mem_req_addr,
    .mem_rsp_valid, .mem_rsp_ready, .mem_rsp_data
  );

  dcw_hdr_check #(.WORD_W(WORD_W)) u_hdr (
    .hdr(dw[0]), .parity_ok, .linked
  );

  dcw_link_tally #(.WORD_W(WORD_W), .MAX_LINKS(MAX_LINKS)) u_tally (
    .clk, .rst_n, .clr(t_clr), .add(t_add), .len(lk_len),
    .sum(t_sum), .count(t_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= W_IDLE;
      for (int i = 0; i < DESC_WORDS; i++) dw[i] <= '0;
      desc_ptr    <= '0;
      link_ptr    <= '0;
      lk_len      <= '0;
      lk_next     <= '0;
      idx         <= '0;
      half        <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
      code_q      <= FAULT_NONE;
      seg_valid_q <= 1'b0;
      seg_len_q   <= '0;
      seg_addr_q  <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        W_IDLE: if (start) begin
          code_q <= FAULT_NONE;
          if (start_addr == '0 || start_addr[1:0] != 2'b00) begin
            err_q <= 1'b1; code_q <= FAULT_DESC_ADR;
          end else begin
            desc_ptr <= start_addr; idx <= '0; st <= W_DESC_RD;
          end
        end
        W_DESC_RD: if (rd_word_valid) begin
          dw[idx] <= rd_data;
          if (idx == IDX_W'(DESC_WORDS - 1)) st <= W_DESC_CHK;
          else idx <= idx + 1'b1;
        end
        W_DESC_CHK: begin
          if (!parity_ok) begin
            err_q <= 1'b1; code_q <= FAULT_HEADER; st <= W_IDLE;
          end else begin
            half <= 1'b0; st <= W_HALF;
          end
        end
        W_HALF: begin
          if (cur_len == '0 && cur_ptr == '0) begin
            if (half) st <= W_NEXT;
            else half <= 1'b1;
          end else if (linked) begin
            if (cur_ptr == '0 || cur_ptr[1:0] != 2'b00) begin
              err_q <= 1'b1; code_q <= FAULT_LINK_ADR; st <= W_IDLE;
            end else begin
              link_ptr <= cur_ptr; idx <= '0; st <= W_LINK_RD;
            end
          end else begin
            seg_len_q <= cur_len; seg_addr_q <= cur_ptr;
            seg_valid_q <= 1'b1; st <= W_SEG;
          end
        end
        W_SEG: if (seg_ready) begin
          seg_valid_q <= 1'b0;
          if (half) st <= W_NEXT;
          else begin half <= 1'b1; st <= W_HALF; end
        end
        W_LINK_RD: if (rd_word_valid) begin
          case (idx)
            IDX_W'(0): begin lk_len <= rd_data; idx <= idx + 1'b1; end
            IDX_W'(1): begin seg_addr_q <= rd_data; idx <= idx + 1'b1; end
            default: begin
              lk_next <= rd_data; seg_len_q <= lk_len;
              seg_valid_q <= 1'b1; st <= W_LINK_SEG;
            end
          endcase
        end
        W_LINK_SEG: if (seg_ready) begin
          seg_valid_q <= 1'b0;
          if (lk_next == '0) st <= W_CHAIN_END;
          else if (t_cnt == CNT_W'(MAX_LINKS)) begin
            err_q <= 1'b1; code_q <= FAULT_LINK_CNT; st <= W_IDLE;
          end else if (lk_next[1:0] != 2'b00) begin
            err_q <= 1'b1; code_q <= FAULT_LINK_ADR; st <= W_IDLE;
          end else begin
            link_ptr <= lk_next; idx <= '0; st <= W_LINK_RD;
          end
        end
        W_CHAIN_END: begin
          if (t_sum != SUM_W'(cur_len)) begin
            err_q <= 1'b1; code_q <= FAULT_LINK_LEN; st <= W_IDLE;
          end else if (half) st <= W_NEXT;
          else begin half <= 1'b1; st <= W_HALF; end
        end
        W_NEXT: begin
          if (dw[5] == '0) begin
            done_q <= 1'b1; st <= W_IDLE;
          end else if (dw[5][1:0] != 2'b00) begin
            err_q <= 1'b1; code_q <= FAULT_DESC_ADR; st <= W_IDLE;
          end else begin
            desc_ptr <= dw[5]; idx <= '0; st <= W_DESC_RD;
          end
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  assign busy      = (st != W_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign err_code  = code_q;
  assign seg_valid = seg_valid_q;
  assign seg_len   = seg_len_q;
  assign seg_addr  = seg_addr_q;
  assign seg_dir   = half;

  assert_seg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !seg_ready |=> seg_valid && $stable(seg_len) && $stable(seg_addr) && $stable(seg_dir));
  assert_single_outcome_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> !(done && err) && !busy);
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !seg_valid && !mem_req_valid && !mem_rsp_ready);
  assert_no_read_during_seg_R1: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> !mem_req_valid);
endmodule

// File: tb/test_desc_chain_walker.sv
`timescale 1ns/1ps
module test_desc_chain_walker;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] start_addr = '0;
  logic busy, done, err, mem_req_valid, mem_rsp_ready, seg_valid, seg_dir;
  logic [3:0] err_code;
  logic [31:0] mem_req_addr, seg_len, seg_addr;
  logic mem_req_ready = 1'b0, mem_rsp_valid = 1'b0, seg_ready = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  always #2 clk = ~clk;

  desc_chain_walker i_desc_chain_walker (
    .clk, .rst_n, .start, .start_addr, .busy, .done, .err, .err_code,
    .mem_req_valid, .mem_req_ready, .mem_req_addr,
    .mem_rsp_valid, .mem_rsp_ready, .mem_rsp_data,
    .seg_valid, .seg_ready, .seg_len, .seg_addr, .seg_dir
  );

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] mem [0:1023];
  logic [64:0] expq [$];
  logic [31:0] alloc_ptr;
  bit got_done, got_err;
  bit req_will = 0, rsp_will = 0, pend = 0;
  logic [31:0] cap_addr, paddr;
  int lat = 0;

  task automatic check(input bit ok, input string req, input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory, segment sink and outcome monitor
  always @(negedge clk) begin
    cycles++;
    if (rsp_will) mem_rsp_valid = 1'b0;
    if (req_will) begin pend = 1; paddr = cap_addr; lat = $urandom % 3; end
    if (pend && !mem_rsp_valid) begin
      if (lat == 0) begin
        mem_rsp_valid = 1'b1; mem_rsp_data = mem[paddr[11:2]]; pend = 0;
      end else lat--;
    end
    mem_req_ready = ($urandom % 4) != 0;
    seg_ready     = ($urandom % 4) != 0;
    req_will = mem_req_valid && mem_req_ready;
    cap_addr = mem_req_addr;
    rsp_will = mem_rsp_valid && mem_rsp_ready;
    if (seg_valid && seg_ready) begin
      if (expq.size() == 0)
        check(1'b0, "R3_R5_unexpected_segment", {seg_dir, seg_len, seg_addr}, '0);
      else begin
        logic [64:0] e;
        e = expq.pop_front();
        check({seg_dir, seg_len, seg_addr} == e, "R3_R5_segment", {seg_dir, seg_len, seg_addr}, e);
      end
    end
    if (done) got_done = 1;
    if (err) got_err = 1;
    if (cycles > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog R13 actual=%0d expected=%0d", cycles, 190000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] mk_hdr(input bit lk, input bit bad);
    logic [31:0] h;
    h = {4'h1, 3'b000, lk, 8'h05, 16'h0000};
    h[31] = ~(^h[30:0]);
    if (bad) h[31] = ~h[31];
    return h;
  endfunction

  function automatic logic [31:0] alloc(input int words);
    logic [31:0] a;
    a = alloc_ptr;
    alloc_ptr = alloc_ptr + 32'(words * 4);
    return a;
  endfunction

  task automatic put(input logic [31:0] a, input logic [31:0] d);
    mem[a[11:2]] = d;
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] h, input logic [31:0] l1,
                          input logic [31:0] p1, input logic [31:0] l2, input logic [31:0] p2,
                          input logic [31:0] nx);
    put(a, h); put(a + 4, l1); put(a + 8, p1); put(a + 12, l2); put(a + 16, p2); put(a + 20, nx);
  endtask

  // builds a chain of n links, queues their segments, returns head and total length
  task automatic make_links(input int n, input bit dir, output logic [31:0] head, output logic [31:0] total);
    logic [31:0] base;
    base = alloc(3 * n);
    head = base;
    total = 0;
    for (int i = 0; i < n; i++) begin
      logic [31:0] la, ln, da;
      la = base + 32'(12 * i);
      ln = 1 + ($urandom % 64);
      da = {$urandom} & 32'hFFFF_FFF0;
      put(la, ln); put(la + 4, da); put(la + 8, (i == n - 1) ? 32'h0 : la + 12);
      total = total + ln;
      expq.push_back({dir, ln, da});
    end
  endtask

  task automatic run(input logic [31:0] a, input bit exp_err, input logic [3:0] exp_code,
                     input string req, input bit poke);
    int t;
    got_done = 0; got_err = 0;
    @(negedge clk); start = 1'b1; start_addr = a;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      start = 1'b1; start_addr = 32'h0000_0F00;  // R12: ignored while busy
      @(negedge clk); start = 1'b0;
    end
    t = 0;
    while (!(got_done || got_err) && t < 20000) begin @(negedge clk); t++; end
    check(got_err == exp_err && got_done == !exp_err, {req, "_outcome"}, {got_done, got_err}, {!exp_err, exp_err});
    check(err_code == exp_code, {req, "_code"}, err_code, exp_code);
    check(expq.size() == 0, {req, "_all_segments"}, expq.size(), 0);
    check(!busy, "R13_busy_low", busy, 0);
    expq.delete();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d0, d1, h1, h2, t1, t2;
    void'($urandom(32'd2024));
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !seg_valid && !mem_req_valid && !done && !err && err_code == 0,
          "R13_reset_state", {busy, seg_valid, mem_req_valid, done, err, err_code}, '0);

    // R3 R10: direct halves, single descriptor
    alloc_ptr = 32'h40;
    d0 = alloc(6);
    put_desc(d0, mk_hdr(0, 0), 32'd100, 32'h1000_0000, 32'd100, 32'h2000_0000, 0);
    expq.push_back({1'b0, 32'd100, 32'h1000_0000});
    expq.push_back({1'b1, 32'd100, 32'h2000_0000});
    run(d0, 0, 0, "R3", 0);

    // R4: input half skipped
    alloc_ptr = 32'h40;
    d0 = alloc(6);
    put_desc(d0, mk_hdr(0, 0), 0, 0, 32'd16, 32'h3000_0000, 0);
    expq.push_back({1'b1, 32'd16, 32'h3000_0000});
    run(d0, 0, 0, "R4", 0);

    // R5 R12: linked halves, start poked while busy
    alloc_ptr = 32'h40;
    d0 = alloc(6);
    make_links(3, 0, h1, t1);
    make_links(2, 1, h2, t2);
    put_desc(d0, mk_hdr(1, 0), t1, h1, t2, h2, 0);
    put_desc(32'h0F00, mk_hdr(0, 0), 32'd1, 32'h4, 32'd1, 32'h4, 0);
    run(d0, 0, 0, "R5_R12", 1);

    // R10: two descriptors chained
    alloc_ptr = 32'h40;
    d0 = alloc(6); d1 = alloc(6);
    put_desc(d0, mk_hdr(0, 0), 32'd32, 32'hA000_0000, 0, 0, d1);
    expq.push_back({1'b0, 32'd32, 32'hA000_0000});
    make_links(2, 0, h1, t1);
    put_desc(d1, mk_hdr(1, 0), t1, h1, 0, 0, 0);
    run(d0, 0, 0, "R10", 0);

    // R2: bad parity
    alloc_ptr = 32'h40;
    d0 = alloc(6);
    put_desc(d0, mk_hdr(0, 1), 32'd8, 32'h100, 32'd8, 32'h200, 0);
    run(d0, 1, 4'd1, "R2", 0);

    // R6: link total differs from half length
    alloc_ptr = 32'h40;
    d0 = alloc(6);
    make_links(3, 0, h1, t1);
    put_desc(d0, mk_hdr(1, 0), t1 + 1, h1, 0, 0, 0);
    run(d0, 1, 4'd4, "R6", 0);

    // R7: exactly MAX links is fine
    alloc_ptr = 32'h40;
    d0 = alloc(6);
    make_links(20, 0, h1, t1);
    put_desc(d0, mk_hdr(1, 0), t1, h1, 0, 0, 0);
    run(d0, 0, 0, "R7_limit_ok", 0);

    // R7: one link too many
    alloc_ptr = 32'h40;
    d0 = alloc(6);
    make_links(21, 0, h1, t1);
    void'(expq.pop_back());
    put_desc(d0, mk_hdr(1, 0), t1, h1, 0, 0, 0);
    run(d0, 1, 4'd5, "R7_overrun", 0);

    // R8: misaligned chain head, and zero head
    alloc_ptr = 32'h40;
    d0 = alloc(6);
    put_desc(d0, mk_hdr(1, 0), 32'd8, 32'h0000_0102, 0, 0, 0);
    run(d0, 1, 4'd13, "R8_head", 0);
    put_desc(d0, mk_hdr(1, 0), 0, 0, 32'd8, 0, 0);
    run(d0, 1, 4'd13, "R8_zero_head", 0);

    // R9: bad start addresses and misaligned next descriptor
    run(32'h0, 1, 4'd12, "R9_zero", 0);
    run(32'h0000_0046, 1, 4'd12, "R9_unaligned", 0);
    alloc_ptr = 32'h40;
    d0 = alloc(6);
    put_desc(d0, mk_hdr(0, 0), 32'd4, 32'h5000_0000, 0, 0, 32'h0000_0203);
    expq.push_back({1'b0, 32'd4, 32'h5000_0000});
    run(d0, 1, 4'd12, "R9_next", 0);

    // random chains (R1 R3 R4 R5 R10 R11 R13)
    for (int r = 0; r < 30; r++) begin
      int nd;
      logic [31:0] da [3];
      alloc_ptr = 32'h40;
      nd = 1 + ($urandom % 3);
      for (int k = 0; k < nd; k++) da[k] = alloc(6);
      for (int k = 0; k < nd; k++) begin
        bit lk;
        logic [31:0] l [2], p [2];
        lk = $urandom % 2;
        for (int hf = 0; hf < 2; hf++) begin
          if ($urandom % 5 == 0) begin l[hf] = 0; p[hf] = 0; end
          else if (lk) make_links(1 + ($urandom % 4), hf[0], p[hf], l[hf]);
          else begin
            l[hf] = 1 + ($urandom % 4096);
            p[hf] = ({$urandom} & 32'hFFFF_FFFC) | 32'h4;
            expq.push_back({hf[0], l[hf], p[hf]});
          end
        end
        put_desc(da[k], mk_hdr(lk, 0), l[0], p[0], l[1], p[1], (k == nd - 1) ? 32'h0 : da[k + 1]);
      end
      run(da[0], 0, 0, "R1_random", 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule